// File: doc/BRIEF.md
# CAN Frame Error Detector

This block watches a CAN bit stream one sampled bit at a time and flags the five protocol error classes: bit, stuff, CRC, form and acknowledgment. A protocol sequencer elsewhere in the controller owns frame parsing and bit timing. At each bit-time strobe it presents the sampled bus level and the level the node is driving. It also gives a flag that says whether the node is transmitting, and a code for the frame field the current bit belongs to. The detector removes stuff bits itself and accumulates the CRC. It checks the fixed-form fields and reports each violation as a one-cycle pulse. Error counters and error-frame generation are left to the sequencer.

Logic 0 on the bus is dominant and logic 1 is recessive. The field code is 0 idle, 1 arbitration (its first bit is the start of frame), 2 control and data, 3 CRC, 4 CRC delimiter, 5 acknowledge slot, 6 acknowledge delimiter, 7 end of frame, and 8 error frame.

Top module: `can_err_detect`

## Requirements
- R1: While the field code is 1, 2 or 3, a bit of the same level as the five bits before it raises `err_stuff`.
- R2: The bit that follows five equal bits in fields 1 to 3 is a stuff bit. It is kept out of the CRC and out of the received CRC value, and a new run of equal bits starts with it. The first strobed bit in fields 1 to 3 after any other field, or after reset, is the start of frame. It restarts both the run count and the CRC.
- R3: The CRC is 15 bits wide, uses polynomial 0x4599 and starts at zero. It covers the destuffed bits of fields 1 and 2. The first 15 destuffed bits of field 3 form the received CRC, most significant bit first. On the 15th of them, `err_crc` is raised if that value differs from the computed CRC.
- R4: A dominant bit in field 4, 6 or 7 raises `err_form`.
- R5: A recessive bit in field 5 while `tx_active` is high raises `err_ack`. With `tx_active` low, field 5 raises nothing.
- R6: While `tx_active` is high, a sampled bit that differs from `tx_bit` raises `err_bit`, except in the two masked cases below. With `tx_active` low, `err_bit` is never raised.
- R7: In field 1, a recessive `tx_bit` read back as dominant does not raise `err_bit` (lost arbitration).
- R8: In field 5, a recessive `tx_bit` read back as dominant does not raise `err_bit`. This covers the acknowledgement and an error flag that overlaps the slot.
- R9: Every error output is registered. It is high for exactly the one clock cycle after the clock edge that takes a strobe with a violation, and it stays low after any edge without a strobe.
- R10: Synchronous reset clears all outputs and the run, start-of-frame and CRC state.
- R11: Fields 0 and 4 to 8 raise no stuff error, however long a run of equal bits they carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle strobe, one per bit time |
| rx_bit | input | 1 | Sampled bus level (0 dominant) |
| tx_bit | input | 1 | Level this node drives |
| tx_active | input | 1 | Node is the transmitter of the current frame |
| field | input | 4 | Field code of the current bit |
| err_bit | output | 1 | Bit error pulse |
| err_stuff | output | 1 | Stuff error pulse |
| err_crc | output | 1 | CRC mismatch pulse |
| err_form | output | 1 | Form error pulse |
| err_ack | output | 1 | Acknowledgment error pulse |

## Verification
Some rules can be judged from a single strobe: that every pulse follows a strobe, the field and level that caused each form, ack and bit pulse, the two bit-check masks, and which fields may raise stuff or CRC errors. The assertions check these on every cycle. Whether a stuff error sits on the correct sixth bit, whether stuff bits are really kept out of the CRC, and whether the 15-bit comparison lands on the right bit all depend on the history of a whole frame. Only the bench's generated frames can show those, with corrupted CRCs, removed stuff bits and lost-arbitration patterns among them.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    typedef enum logic [3:0] {
        FLD_IDLE     = 4'd0,
        FLD_ARB      = 4'd1,
        FLD_DATA     = 4'd2,
        FLD_CRC      = 4'd3,
        FLD_CRC_DEL  = 4'd4,
        FLD_ACK_SLOT = 4'd5,
        FLD_ACK_DEL  = 4'd6,
        FLD_EOF      = 4'd7,
        FLD_ERRFRM   = 4'd8
    } fld_e;

    typedef struct packed {
        logic bit_e;
        logic stuff_e;
        logic crc_e;
        logic form_e;
        logic ack_e;
    } err_s;

    // Fields subject to bit stuffing
    function automatic logic in_stuff_region(fld_e f);
        return (f == FLD_ARB) || (f == FLD_DATA) || (f == FLD_CRC);
    endfunction

    // Fields whose level is fixed recessive
    function automatic logic fixed_recessive(fld_e f);
        return (f == FLD_CRC_DEL) || (f == FLD_ACK_DEL) || (f == FLD_EOF);
    endfunction

    // Fields the computed CRC covers
    function automatic logic crc_covered(fld_e f);
        return (f == FLD_ARB) || (f == FLD_DATA);
    endfunction

endpackage

// File: rtl/can_destuff.sv
module can_destuff #(
    parameter int RUN_MAX = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic rxb,
    input  logic in_reg,
    output logic data_vld,
    output logic sof,
    output logic stuff_err
);
    localparam int RW = $clog2(RUN_MAX + 1);

    logic          prev_in;
    logic [RW-1:0] run_len;
    logic          last_lvl;
    logic          first_bit;
    logic          stuff_pos;

    always_comb begin
        first_bit = in_reg && !prev_in;
        stuff_pos = in_reg && prev_in && (run_len == RW'(RUN_MAX));
        sof       = stb && first_bit;
        data_vld  = stb && in_reg && !stuff_pos;
        stuff_err = stb && stuff_pos && (rxb == last_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_in  <= 1'b0;
            run_len  <= '0;
            last_lvl <= 1'b1;
        end else if (stb) begin
            prev_in <= in_reg;
            if (in_reg) begin
                if (first_bit || stuff_pos || (rxb != last_lvl)) begin
                    run_len  <= RW'(1);
                    last_lvl <= rxb;
                end else begin
                    run_len <= run_len + RW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/can_crc_chk.sv
module can_crc_chk #(
    parameter int             CRC_W    = 15,
    parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
    input  logic clk,
    input  logic rst,
    input  logic dvld,
    input  logic sof,
    input  logic rxb,
    input  logic crc_fld,
    input  logic cover_fld,
    output logic crc_err
);
    localparam int CW = $clog2(CRC_W + 1);

    logic [CRC_W-1:0] calc_q, rxval_q;
    logic [CW-1:0]    cnt_q;
    logic [CRC_W-1:0] calc_base, rx_base, calc_nxt, rx_nxt;
    logic [CW-1:0]    cnt_base;

    function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
        logic [CRC_W-1:0] s;
        s = {c[CRC_W-2:0], 1'b0};
        if (b ^ c[CRC_W-1]) s = s ^ CRC_POLY;
        return s;
    endfunction

    always_comb begin
        calc_base = sof ? '0 : calc_q;
        rx_base   = sof ? '0 : rxval_q;
        cnt_base  = sof ? '0 : cnt_q;
        calc_nxt  = crc_step(calc_base, rxb);
        rx_nxt    = {rx_base[CRC_W-2:0], rxb};
        crc_err   = dvld && crc_fld && (cnt_base == CW'(CRC_W - 1)) && (rx_nxt != calc_base);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            calc_q  <= '0;
            rxval_q <= '0;
            cnt_q   <= '0;
        end else if (dvld) begin
            calc_q  <= cover_fld ? calc_nxt : calc_base;
            rxval_q <= rx_base;
            cnt_q   <= cnt_base;
            if (crc_fld && (cnt_base < CW'(CRC_W))) begin
                rxval_q <= rx_nxt;
                cnt_q   <= cnt_base + CW'(1);
            end
        end
    end
endmodule

// File: rtl/can_field_chk.sv
module can_field_chk
    import can_err_pkg::*;
(
    input  logic stb,
    input  fld_e fld,
    input  logic rxb,
    input  logic txb,
    input  logic tx_active,
    output logic bit_err,
    output logic form_err,
    output logic ack_err
);
    logic overridden;

    always_comb begin
        // recessive sent, dominant read: allowed in arbitration and ack slot
        overridden = txb && !rxb && ((fld == FLD_ARB) || (fld == FLD_ACK_SLOT));
        bit_err    = stb && tx_active && (rxb != txb) && !overridden;
        form_err   = stb && fixed_recessive(fld) && !rxb;
        ack_err    = stb && tx_active && (fld == FLD_ACK_SLOT) && rxb;
    end
endmodule

// File: rtl/can_err_detect.sv
module can_err_detect
    import can_err_pkg::*;
#(
    parameter int               RUN_MAX  = 5,
    parameter int               CRC_W    = 15,
    parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       rx_bit,
    input  logic       tx_bit,
    input  logic       tx_active,
    input  logic [3:0] field,
    output logic       err_bit,
    output logic       err_stuff,
    output logic       err_crc,
    output logic       err_form,
    output logic       err_ack
);
    fld_e fld;
    logic data_vld, sof;
    err_s err_d, err_q;

    assign fld = fld_e'(field);

    can_destuff #(.RUN_MAX(RUN_MAX)) u_destuff (
        .clk      (clk),
        .rst      (rst),
        .stb      (bit_stb),
        .rxb      (rx_bit),
        .in_reg   (in_stuff_region(fld)),
        .data_vld (data_vld),
        .sof      (sof),
        .stuff_err(err_d.stuff_e)
    );

    can_crc_chk #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
        .clk      (clk),
        .rst      (rst),
        .dvld     (data_vld),
        .sof      (sof),
        .rxb      (rx_bit),
        .crc_fld  (fld == FLD_CRC),
        .cover_fld(crc_covered(fld)),
        .crc_err  (err_d.crc_e)
    );

    can_field_chk u_fixed (
        .stb      (bit_stb),
        .fld      (fld),
        .rxb      (rx_bit),
        .txb      (tx_bit),
        .tx_active(tx_active),
        .bit_err  (err_d.bit_e),
        .form_err (err_d.form_e),
        .ack_err  (err_d.ack_e)
    );

    always_ff @(posedge clk) begin
        if (rst)          err_q <= '0;
        else if (bit_stb) err_q <= err_d;
        else              err_q <= '0;
    end

    assign err_bit   = err_q.bit_e;
    assign err_stuff = err_q.stuff_e;
    assign err_crc   = err_q.crc_e;
    assign err_form  = err_q.form_e;
    assign err_ack   = err_q.ack_e;
endmodule

// File: rtl/can_err_detect_chk.sv
module can_err_detect_chk
    import can_err_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bit_stb,
    input logic       rx_bit,
    input logic       tx_bit,
    input logic       tx_active,
    input logic [3:0] field,
    input logic       err_bit,
    input logic       err_stuff,
    input logic       err_crc,
    input logic       err_form,
    input logic       err_ack
);
    a_r9_pulse_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (err_bit || err_stuff || err_crc || err_form || err_ack) |-> $past(bit_stb));

    a_r1_stuff_in_region: assert property (@(posedge clk) disable iff (rst)
        err_stuff |-> ($past(field) == FLD_ARB || $past(field) == FLD_DATA
                       || $past(field) == FLD_CRC));

    a_r3_crc_in_crc_field: assert property (@(posedge clk) disable iff (rst)
        err_crc |-> ($past(field) == FLD_CRC));

    a_r4_form_cause: assert property (@(posedge clk) disable iff (rst)
        err_form |-> (($past(field) == FLD_CRC_DEL || $past(field) == FLD_ACK_DEL
                       || $past(field) == FLD_EOF) && !$past(rx_bit)));

    a_r5_ack_cause: assert property (@(posedge clk) disable iff (rst)
        err_ack |-> ($past(field) == FLD_ACK_SLOT && $past(rx_bit) && $past(tx_active)));

    a_r6_bit_cause: assert property (@(posedge clk) disable iff (rst)
        err_bit |-> ($past(tx_active) && ($past(rx_bit) != $past(tx_bit))));

    a_r7_arb_mask: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && field == FLD_ARB && tx_bit && !rx_bit) |=> !err_bit);

    a_r8_ack_mask: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && field == FLD_ACK_SLOT && tx_bit && !rx_bit) |=> !err_bit);
endmodule

bind can_err_detect can_err_detect_chk u_chk (.*);

// File: tb/can_err_detect_bench.sv
module can_err_detect_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0, rx_bit = 1'b1, tx_bit = 1'b1, tx_active = 1'b0;
    logic [3:0] field = 4'd0;
    logic       err_bit, err_stuff, err_crc, err_form, err_ack;

    int n_vec = 0, n_bad = 0;

    // bench reference state
    bit          m_prev;
    int          m_run, m_cnt;
    bit          m_last;
    logic [14:0] m_crc, m_rx;

    // frame builder state
    bit pay [0:127];
    int s_run, sent_cnt, bit_err_at;
    bit s_last, viol_pending, tx_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_err_detect u_can_err_detect (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .rx_bit(rx_bit), .tx_bit(tx_bit),
        .tx_active(tx_active), .field(field), .err_bit(err_bit), .err_stuff(err_stuff),
        .err_crc(err_crc), .err_form(err_form), .err_ack(err_ack)
    );

    function automatic logic [14:0] bstep(logic [14:0] c, bit b);
        logic [14:0] s;
        s = {c[13:0], 1'b0};
        if (b ^ c[14]) s = s ^ 15'h4599;
        return s;
    endfunction

    task automatic model_reset();
        m_prev = 0; m_run = 0; m_last = 1; m_crc = '0; m_rx = '0; m_cnt = 0;
    endtask

    // expected {bit, stuff, crc, form, ack} from the requirements
    task automatic model(input logic [3:0] f, input bit b, input bit t, input bit ta,
                         output bit [4:0] e);
        bit inr, dat;
        e = '0; dat = 0;
        inr = (f == 4'd1 || f == 4'd2 || f == 4'd3);
        if (inr) begin
            if (!m_prev) begin                 // R2 start of frame
                m_run = 1; m_last = b; m_crc = '0; m_rx = '0; m_cnt = 0; dat = 1;
            end else if (m_run == 5) begin     // R2 stuff position
                if (b == m_last) e[3] = 1;     // R1
                m_run = 1; m_last = b;
            end else begin
                dat = 1;
                if (b == m_last) m_run++;
                else begin m_run = 1; m_last = b; end
            end
            if (dat) begin
                if (f == 4'd3) begin
                    if (m_cnt < 15) begin      // R3
                        if (m_cnt == 14 && {m_rx[13:0], b} != m_crc) e[2] = 1;
                        m_rx = {m_rx[13:0], b};
                        m_cnt++;
                    end
                end else m_crc = bstep(m_crc, b);
            end
        end
        m_prev = inr;
        e[1] = (f == 4'd4 || f == 4'd6 || f == 4'd7) && !b;                    // R4
        e[0] = (f == 4'd5) && ta && b;                                          // R5
        e[4] = ta && (b != t) && !((f == 4'd1 || f == 4'd5) && t && !b);        // R6 R7 R8
    endtask

    task automatic compare(input bit [4:0] e, input string tag);
        bit [4:0] a;
        a = {err_bit, err_stuff, err_crc, err_form, err_ack};
        n_vec++;
        if (a != e) begin
            n_bad++;
            if (a[4] != e[4]) $display("FAIL %s R6 err_bit act=%0b exp=%0b", tag, a[4], e[4]);
            if (a[3] != e[3]) $display("FAIL %s R1 err_stuff act=%0b exp=%0b", tag, a[3], e[3]);
            if (a[2] != e[2]) $display("FAIL %s R3 err_crc act=%0b exp=%0b", tag, a[2], e[2]);
            if (a[1] != e[1]) $display("FAIL %s R4 err_form act=%0b exp=%0b", tag, a[1], e[1]);
            if (a[0] != e[0]) $display("FAIL %s R5 err_ack act=%0b exp=%0b", tag, a[0], e[0]);
        end
    endtask

    // one strobe; the result is registered at the next edge and read one negedge later
    task automatic drive(input logic [3:0] f, input bit b, input bit t, input bit ta);
        bit [4:0] e;
        @(negedge clk);
        field = f; rx_bit = b; tx_bit = t; tx_active = ta; bit_stb = 1'b1;
        model(f, b, t, ta, e);
        @(negedge clk);
        bit_stb = 1'b0;
        compare(e, "strobe");
        if ($urandom_range(0, 3) == 0) begin
            rx_bit = ~rx_bit;
            @(negedge clk);
            compare(5'b0, "R9 gap");
        end
    endtask

    task automatic put(input logic [3:0] f, input bit b);
        bit r;
        r = b ^ (sent_cnt == bit_err_at);
        sent_cnt++;
        drive(f, r, tx_mode ? b : r, tx_mode);
    endtask

    task automatic put_stuffed(input logic [3:0] f, input bit b);
        if (s_run == 5) begin
            if (viol_pending) begin put(f, s_last); viol_pending = 0; end
            else begin put(f, ~s_last); s_last = ~s_last; end
            s_run = 1;
        end
        put(f, b);
        if (b == s_last) s_run++;
        else begin s_run = 1; s_last = b; end
    endtask

    task automatic build_payload(input int nd, input bit long_run);
        pay[0] = 0;
        for (int i = 1; i < 12 + nd; i++)
            pay[i] = ($urandom_range(0, 3) == 0) ? ~pay[i-1] : pay[i-1];
        if (long_run) for (int i = 1; i < 7; i++) pay[i] = 0;
    endtask

    task automatic send_frame(input int nd, input bit bad_crc, input bit stuff_viol,
                              input bit acked, input bit bad_form, input bit txm,
                              input int berr);
        logic [14:0] c;
        int n;
        n = 12 + nd;
        tx_mode = txm; bit_err_at = berr; sent_cnt = 0;
        s_run = 0; s_last = 1; viol_pending = stuff_viol;
        c = '0;
        for (int i = 0; i < n; i++) c = bstep(c, pay[i]);
        if (bad_crc) c[3] = ~c[3];
        for (int i = 0; i < n; i++) put_stuffed(i < 12 ? 4'd1 : 4'd2, pay[i]);
        for (int i = 14; i >= 0; i--) put_stuffed(4'd3, c[i]);
        put(4'd4, 1'b1);
        drive(4'd5, acked ? 1'b0 : 1'b1, 1'b1, txm);
        put(4'd6, 1'b1);
        for (int i = 0; i < 7; i++) put(4'd7, !(bad_form && i == 3));
        for (int i = 0; i < 4; i++) put(4'd0, 1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'hC0FFEE));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare(5'b0, "R10 reset");

        // clean frame, transmitter, acknowledged: no error anywhere (R2 R3)
        build_payload(16, 1);
        send_frame(16, 0, 0, 1, 0, 1, -1);
        // corrupted CRC (R3)
        build_payload(8, 1);
        send_frame(8, 1, 0, 1, 0, 1, -1);
        // stuff violation at the first stuff position (R1)
        build_payload(8, 1);
        send_frame(8, 0, 1, 1, 0, 0, -1);
        // no acknowledgement, and form violation in end of frame (R5 R4)
        build_payload(4, 0);
        send_frame(4, 0, 0, 0, 1, 1, -1);
        // receiver sees missing ack: no ack error (R5)
        build_payload(4, 0);
        send_frame(4, 0, 0, 0, 0, 0, -1);
        // bit error in data field (R6)
        build_payload(8, 0);
        send_frame(8, 0, 0, 1, 0, 1, 15);
        // lost arbitration: recessive sent, dominant read (R7)
        drive(4'd0, 1, 1, 1);
        drive(4'd1, 0, 0, 1);
        drive(4'd1, 0, 1, 1);
        drive(4'd1, 1, 0, 1);
        // ack slot override and error-frame bits (R8 R6)
        drive(4'd5, 0, 1, 1);
        drive(4'd8, 0, 1, 1);
        drive(4'd8, 1, 1, 1);
        // long recessive runs outside stuffed fields (R11)
        for (int i = 0; i < 12; i++) drive(4'd0, 1, 1, 0);
        for (int i = 0; i < 8; i++) drive(4'd7, 1, 1, 0);
        for (int i = 0; i < 8; i++) drive(4'd8, 0, 0, 0);

        // reset mid-run clears run state (R10)
        drive(4'd1, 0, 0, 0);
        drive(4'd1, 0, 0, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        @(negedge clk);
        compare(5'b0, "R10 reset mid");

        // random frames
        for (int k = 0; k < 120; k++) begin
            int nd;
            nd = $urandom_range(0, 64);
            build_payload(nd, $urandom_range(0, 1));
            send_frame(nd, $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
                       $urandom_range(0, 4) != 0, $urandom_range(0, 5) == 0,
                       $urandom_range(0, 1), $urandom_range(0, 3) == 0 ? $urandom_range(0, 90) : -1);
        end

        // random fields and levels
        for (int k = 0; k < 3000; k++)
            drive(4'($urandom_range(0, 8)), $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 1));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule